// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host register accesses into the pin-level bus cycles of a raw 8-bit NAND flash device. A write to the command port produces one command-latch cycle, and a write to the address port produces one address-latch cycle. A read or write of the data port produces a single byte transfer. Every bus cycle has three phases: latch setup, strobe active and hold. The length of each phase, in controller clocks, is programmed as the wanted count minus one.

The block also holds a controller enable bit and an active-low chip-enable control bit. It synchronises the ready/busy pin into a status bit. While a flash cycle runs, the host handshake (`h_valid`/`h_ready`) is held off, so a following access waits and is not lost.

The sequencer is a four-state machine:
- `ST_IDLE` goes to `ST_SETUP` when a flash access is accepted while the controller is enabled.
- `ST_SETUP` goes to `ST_STROBE` when its counter reaches zero.
- `ST_STROBE` goes to `ST_HOLD` when its counter reaches zero. A read captures its byte on this transition.
- `ST_HOLD` returns to `ST_IDLE` when its counter reaches zero. `h_ready` is high in that last hold clock.

Register select map (`h_sel`):

| Select | Name | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | bit 0 = enable, bit 1 = chip-enable off |
| 1 | SETUP | read/write | setup length minus one |
| 2 | PULSE | read/write | bits [2:0] = strobe length minus one, bits [6:4] = hold length minus one |
| 3 | STATUS | read only | bit 0 = ready |
| 4 | CMD | write only | command byte |
| 5 | ADDR | write only | address byte |
| 6 | DATA | read/write | data byte |

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the pins rest as follows: `nand_ce_n`=1, CLE=0, ALE=0, `nand_we_n`=1, `nand_re_n`=1, `nand_dq_oe`=0. The registers read back as CTRL=0x02, SETUP=all ones (0x03 in the base variant) and PULSE=0x77.
- R2: A write to select 4 runs one cycle with CLE high through setup, strobe and hold, and ALE low. The written byte is driven on `nand_dq_out` with `nand_dq_oe`=1, and there is exactly one `nand_we_n` low pulse.
- R3: A write to select 5 runs the same cycle as R2, but with ALE high and CLE low.
- R4: The setup phase lasts SETUP+1 clocks and `nand_we_n`/`nand_re_n` stays low for PULSE[2:0]+1 clocks. Hold then lasts PULSE[6:4]+1 clocks. A field value of 0 gives a one-clock phase.
- R5: The setup field is 2 bits wide in the base variant (`EXT_SETUP`=0), for at most 4 clocks, and 3 bits wide in the extended variant. Upper bits written to it are discarded; writing 0xFE reads back 0x02 in the base variant.
- R6: A write to select 6 runs a cycle with CLE and ALE low, the byte driven, and one `nand_we_n` pulse.
- R7: A read of select 6 pulses `nand_re_n` and never drives the bus. It returns on `h_rdata` the byte present on `nand_dq_in` at the clock edge that ends the strobe phase.
- R8: `h_ready` stays low from the accept of a flash access until the last hold clock. Back-to-back accesses each produce their own cycle, in order.
- R9: CTRL bit 1 drives `nand_ce_n` directly: 1 deselects the device and 0 selects it.
- R10: STATUS bit 0 equals `nand_rb` delayed by two clocks: 1 means ready and 0 means busy.
- R11: While CTRL bit 0 is clear, flash accesses complete in one clock with no strobe on the pins, and a data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host access request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_sel | input | 3 | Register select |
| h_wdata | input | 8 | Host write byte |
| h_ready | output | 1 | Access completes this clock |
| h_rdata | output | 8 | Host read byte, valid while `h_ready` is high |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench drives the read bus with the expected byte only while `nand_re_n` is low. A design that captures one edge early or one edge late therefore returns 0xEE instead of the byte. All phase lengths are measured at the one-clock minimum, at odd mixed values and at the reset maximum. An off-by-one in count loading shows up as a wrong setup, strobe or hold length. Accesses are issued back to back with `h_valid` held high, so a design that drops a stalled request leaves the scoreboard with unmatched entries. With the controller disabled, any strobe on the pins counts as an unexpected cycle, and so does a completion that takes more than one clock.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_CMD,
        OP_ADDR,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_SETUP  = 3'd1;
    localparam logic [2:0] SEL_PULSE  = 3'd2;
    localparam logic [2:0] SEL_STATUS = 3'd3;
    localparam logic [2:0] SEL_CMD    = 3'd4;
    localparam logic [2:0] SEL_ADDR   = 3'd5;
    localparam logic [2:0] SEL_DATA   = 3'd6;

    localparam int HOLD_LSB = 4;

endpackage

// File: rtl/nand_seq_regs.sv
`timescale 1ns/1ps
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int SETUP_W = 2,
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               nand_rb,
    output logic               ctrl_en,
    output logic               ce_off,
    output logic [SETUP_W-1:0] setup_m1,
    output logic [PHASE_W-1:0] pulse_m1,
    output logic [PHASE_W-1:0] hold_m1,
    output logic               status_rdy,
    output logic [DATA_W-1:0]  rd_data
);

    logic rb_meta;

    // configuration registers, reset to the slowest timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ce_off   <= 1'b1;
            setup_m1 <= '1;
            pulse_m1 <= '1;
            hold_m1  <= '1;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    ctrl_en <= wdata[0];
                    ce_off  <= wdata[1];
                end
                SEL_SETUP: setup_m1 <= wdata[SETUP_W-1:0];
                SEL_PULSE: begin
                    pulse_m1 <= wdata[PHASE_W-1:0];
                    hold_m1  <= wdata[HOLD_LSB +: PHASE_W];
                end
                default: ;
            endcase
        end
    end

    // two-stage synchroniser for the ready/busy pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_meta    <= 1'b0;
            status_rdy <= 1'b0;
        end else begin
            rb_meta    <= nand_rb;
            status_rdy <= rb_meta;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_data[0] = ctrl_en;
                rd_data[1] = ce_off;
            end
            SEL_SETUP: rd_data[SETUP_W-1:0] = setup_m1;
            SEL_PULSE: begin
                rd_data[PHASE_W-1:0]          = pulse_m1;
                rd_data[HOLD_LSB +: PHASE_W]  = hold_m1;
            end
            SEL_STATUS: rd_data[0] = status_rdy;
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_seq_fsm.sv
`timescale 1ns/1ps
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int SETUP_W = 2,
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  bus_op_e            op_in,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [SETUP_W-1:0] setup_m1,
    input  logic [PHASE_W-1:0] pulse_m1,
    input  logic [PHASE_W-1:0] hold_m1,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               idle,
    output logic               done,
    output logic [DATA_W-1:0]  rd_byte,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe
);

    localparam int CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

    seq_state_e          state_q, state_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    bus_op_e             op_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // next state and phase counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_SETUP;
                cnt_d   = CNT_W'(setup_m1);
            end
            ST_SETUP: if (cnt_zero) begin
                state_d = ST_STROBE;
                cnt_d   = CNT_W'(pulse_m1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            ST_STROBE: if (cnt_zero) begin
                state_d = ST_HOLD;
                cnt_d   = CNT_W'(hold_m1);
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            ST_HOLD: if (cnt_zero) begin
                state_d = ST_IDLE;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_CMD;
            wdata_q <= '0;
            rd_byte <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start) begin
                op_q    <= op_in;
                wdata_q <= wdata;
            end
            if (state_q == ST_STROBE && cnt_zero && op_q == OP_READ)
                rd_byte <= dq_in;
        end
    end

    // pin outputs decoded from state
    always_comb begin
        cle    = 1'b0;
        ale    = 1'b0;
        we_n   = 1'b1;
        re_n   = 1'b1;
        dq_oe  = 1'b0;
        dq_out = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                cle   = (op_q == OP_CMD);
                ale   = (op_q == OP_ADDR);
                dq_oe = (op_q != OP_READ);
                if (op_q != OP_READ)
                    dq_out = wdata_q;
                if (state_q == ST_STROBE) begin
                    we_n = (op_q == OP_READ);
                    re_n = (op_q != OP_READ);
                end
            end
            default: ;
        endcase
    end

    assign idle = (state_q == ST_IDLE);
    assign done = (state_q == ST_HOLD) && cnt_zero;

endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int EXT_SETUP = 0,
    parameter int PHASE_W   = 3,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [2:0]        h_sel,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_ready,
    output logic [DATA_W-1:0] h_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb
);

    localparam int SETUP_W = (EXT_SETUP != 0) ? 3 : 2;

    logic               ctrl_en, ce_off, status_rdy;
    logic [SETUP_W-1:0] setup_m1;
    logic [PHASE_W-1:0] pulse_m1, hold_m1;
    logic [DATA_W-1:0]  reg_rdata, rd_byte;
    logic               idle, done, is_flash, start, reg_wr;
    bus_op_e            op_sel;

    always_comb begin
        is_flash = 1'b0;
        op_sel   = OP_CMD;
        unique case (h_sel)
            SEL_CMD:  begin is_flash = h_write; op_sel = OP_CMD;  end
            SEL_ADDR: begin is_flash = h_write; op_sel = OP_ADDR; end
            SEL_DATA: begin is_flash = 1'b1;    op_sel = h_write ? OP_WRITE : OP_READ; end
            default: ;
        endcase
    end

    assign start   = idle && h_valid && is_flash && ctrl_en;
    assign reg_wr  = idle && h_valid && h_write && !is_flash;
    assign h_ready = idle ? !(is_flash && ctrl_en) : done;

    always_comb begin
        if (!idle)
            h_rdata = rd_byte;
        else if (is_flash || h_sel == SEL_CMD || h_sel == SEL_ADDR)
            h_rdata = '0;
        else
            h_rdata = reg_rdata;
    end

    assign nand_ce_n = ce_off;

    nand_seq_regs #(
        .SETUP_W (SETUP_W),
        .PHASE_W (PHASE_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (h_sel),
        .wdata      (h_wdata),
        .nand_rb    (nand_rb),
        .ctrl_en    (ctrl_en),
        .ce_off     (ce_off),
        .setup_m1   (setup_m1),
        .pulse_m1   (pulse_m1),
        .hold_m1    (hold_m1),
        .status_rdy (status_rdy),
        .rd_data    (reg_rdata)
    );

    nand_seq_fsm #(
        .SETUP_W (SETUP_W),
        .PHASE_W (PHASE_W),
        .DATA_W  (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_in    (op_sel),
        .wdata    (h_wdata),
        .setup_m1 (setup_m1),
        .pulse_m1 (pulse_m1),
        .hold_m1  (hold_m1),
        .dq_in    (nand_dq_in),
        .idle     (idle),
        .done     (done),
        .rd_byte  (rd_byte),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .dq_out   (nand_dq_out),
        .dq_oe    (nand_dq_oe)
    );

endmodule

// File: rtl/nand_cycle_seq_chk.sv
`timescale 1ns/1ps
module nand_cycle_seq_chk #(
    parameter int PHASE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_ready,
    input logic               nand_cle,
    input logic               nand_ale,
    input logic               nand_we_n,
    input logic               nand_re_n,
    input logic               nand_dq_oe,
    input logic               nand_rb,
    input logic               ctrl_en,
    input logic               status_rdy,
    input logic [PHASE_W-1:0] pulse_m1
);

    logic               strb;
    logic               strb_prev;
    logic [PHASE_W+1:0] run_cnt;
    logic [1:0]         age;

    assign strb = !nand_we_n || !nand_re_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_prev <= 1'b0;
            run_cnt   <= '0;
            age       <= '0;
        end else begin
            strb_prev <= strb;
            run_cnt   <= strb ? run_cnt + 1'b1 : '0;
            if (age != 2'd2)
                age <= age + 1'b1;
        end
    end

    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    assert_stall_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> !h_ready);

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_prev && !strb) |-> (run_cnt == (PHASE_W+2)'(pulse_m1) + 1'b1));

    assert_quiet_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        strb |-> ctrl_en);

    assert_status_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (status_rdy == $past(nand_rb, 2)));

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_ready    (h_ready),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_rb    (nand_rb),
    .ctrl_en    (ctrl_en),
    .status_rdy (status_rdy),
    .pulse_m1   (pulse_m1)
);

// File: tb/nand_cycle_seq_bench.sv
`timescale 1ns/1ps
module nand_cycle_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_valid, h_write;
    logic [2:0] h_sel;
    logic [7:0] h_wdata;
    logic       h_ready;
    logic [7:0] h_rdata;
    logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out;
    logic [7:0] nand_dq_in;
    logic       nand_rb;

    always #5 clk = ~clk;

    nand_cycle_seq u_nand_cycle_seq (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_write(h_write), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    typedef struct {
        bit         cle;
        bit         ale;
        bit         rd;
        logic [7:0] data;
        int         s;
        int         p;
        int         h;
        string      req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0, n_bad = 0, cyc = 0;
    bit    finished = 1'b0;
    int    cur_s = 4, cur_p = 8, cur_h = 8;
    logic [7:0] rd_val = 8'h00;

    function automatic void chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // flash model: valid byte only while the read strobe is low
    always @(negedge clk) nand_dq_in <= !nand_re_n ? rd_val : 8'hEE;

    // monitor: measures each bus cycle and compares with the scoreboard
    int   m_ph = 0, m_s = 0, m_p = 0, m_h = 0;
    bit   m_cle, m_ale, m_rd, m_oe;
    logic [7:0] m_dq;
    always @(negedge clk) begin
        if (rst_n) begin
            case (m_ph)
                0: if (!nand_we_n || !nand_re_n) begin
                       m_ph = 1; m_p = 1;
                       m_cle = nand_cle; m_ale = nand_ale; m_rd = !nand_re_n;
                       m_dq = nand_dq_out; m_oe = nand_dq_oe;
                   end else if (h_valid && !h_ready) begin
                       m_s++;
                   end
                1: if (!nand_we_n || !nand_re_n) m_p++;
                   else begin m_ph = 2; m_h = 1; end
                default: m_h++;
            endcase
            if (m_ph == 2 && h_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R11 unexpected cycle", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(m_s == e.s, "R4 setup", m_s, e.s);
                    chk(m_p == e.p, "R4 strobe", m_p, e.p);
                    chk(m_h == e.h, "R4 hold", m_h, e.h);
                    chk(m_cle == e.cle && m_ale == e.ale, {e.req, " latch at strobe"},
                        {m_cle, m_ale}, {e.cle, e.ale});
                    chk(nand_cle == e.cle && nand_ale == e.ale, {e.req, " latch in hold"},
                        {nand_cle, nand_ale}, {e.cle, e.ale});
                    chk(m_rd == e.rd, {e.req, " strobe kind"}, m_rd, e.rd);
                    if (e.rd)
                        chk(h_rdata == e.data && !m_oe, "R7 read byte", h_rdata, e.data);
                    else
                        chk(m_dq == e.data && m_oe, {e.req, " bus byte"}, m_dq, e.data);
                end
                m_ph = 0; m_s = 0; m_p = 0; m_h = 0;
            end
        end
    end

    task automatic hx(input logic [2:0] sel, input bit wr, input logic [7:0] d,
                      output logic [7:0] q, output int ncyc);
        int c0;
        h_sel = sel; h_write = wr; h_wdata = d; h_valid = 1'b1;
        c0 = cyc;
        forever begin
            @(negedge clk);
            if (h_ready) begin q = h_rdata; break; end
        end
        @(posedge clk); #1;
        ncyc = cyc - c0;
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d);
        logic [7:0] q; int n;
        hx(sel, 1'b1, d, q, n);
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [7:0] q);
        int n;
        hx(sel, 1'b0, 8'h00, q, n);
    endtask

    task automatic set_timing(input int s, input int p, input int h);
        reg_wr(3'd1, 8'(s - 1));
        reg_wr(3'd2, 8'(((h - 1) << 4) | (p - 1)));
        cur_s = s; cur_p = p; cur_h = h;
    endtask

    task automatic push(input bit c, input bit a, input bit r, input logic [7:0] d, input string req);
        exp_t e;
        e.cle = c; e.ale = a; e.rd = r; e.data = d;
        e.s = cur_s + 1; e.p = cur_p; e.h = cur_h; e.req = req;
        sb.push_back(e);
    endtask

    task automatic do_cmd(input logic [7:0] d);
        logic [7:0] q; int n;
        push(1'b1, 1'b0, 1'b0, d, "R2");
        hx(3'd4, 1'b1, d, q, n);
    endtask

    task automatic do_addr(input logic [7:0] d);
        logic [7:0] q; int n;
        push(1'b0, 1'b1, 1'b0, d, "R3");
        hx(3'd5, 1'b1, d, q, n);
    endtask

    task automatic do_wr(input logic [7:0] d);
        logic [7:0] q; int n;
        push(1'b0, 1'b0, 1'b0, d, "R6");
        hx(3'd6, 1'b1, d, q, n);
    endtask

    task automatic do_rd(input logic [7:0] d);
        logic [7:0] q; int n;
        rd_val = d;
        push(1'b0, 1'b0, 1'b1, d, "R7");
        hx(3'd6, 1'b0, 8'h00, q, n);
    endtask

    task automatic go_idle(input int n);
        h_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int n;
        rst_n = 1'b0; h_valid = 1'b0; h_write = 1'b0; h_sel = 3'd0; h_wdata = 8'h00;
        nand_rb = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(nand_ce_n && !nand_cle && !nand_ale, "R1 pins ce/cle/ale",
            {nand_ce_n, nand_cle, nand_ale}, 3'b100);
        chk(nand_we_n && nand_re_n && !nand_dq_oe, "R1 pins strobes/oe",
            {nand_we_n, nand_re_n, nand_dq_oe}, 3'b110);
        @(posedge clk); #1;
        reg_rd(3'd0, q); chk(q == 8'h02, "R1 CTRL", q, 8'h02);
        reg_rd(3'd1, q); chk(q == 8'h03, "R1 SETUP", q, 8'h03);
        reg_rd(3'd2, q); chk(q == 8'h77, "R1 PULSE", q, 8'h77);

        // R5 setup field width
        reg_wr(3'd1, 8'hFE);
        reg_rd(3'd1, q); chk(q == 8'h02, "R5 setup mask", q, 8'h02);

        // R9 select device, enable controller
        reg_wr(3'd0, 8'h01);
        go_idle(1);
        chk(!nand_ce_n, "R9 ce selected", nand_ce_n, 0);

        // maximal timing
        set_timing(4, 8, 8);
        do_cmd(8'h70);
        do_rd(8'hC3);
        go_idle(2);

        // minimum timing, back to back (R8)
        set_timing(1, 1, 1);
        do_cmd(8'h00);
        do_addr(8'h12);
        do_addr(8'h34);
        do_wr(8'hA5);
        do_rd(8'h5A);
        do_cmd(8'h30);
        go_idle(3);

        // mixed timing
        set_timing(2, 4, 7);
        do_addr(8'h9C);
        do_wr(8'h3E);
        do_rd(8'h81);
        go_idle(1);
        set_timing(3, 8, 3);
        do_wr(8'hFF);
        do_rd(8'h00);
        do_cmd(8'hFF);
        go_idle(2);

        // R10 status follows ready/busy
        nand_rb = 1'b0;
        go_idle(2);
        reg_rd(3'd3, q); chk(q[0] == 1'b0, "R10 busy", q[0], 0);
        nand_rb = 1'b1;
        go_idle(2);
        reg_rd(3'd3, q); chk(q[0] == 1'b1, "R10 ready", q[0], 1);

        // R9 deselect
        reg_wr(3'd0, 8'h03);
        go_idle(1);
        chk(nand_ce_n, "R9 ce deselected", nand_ce_n, 1);

        // R11 controller disabled
        reg_wr(3'd0, 8'h02);
        hx(3'd4, 1'b1, 8'h90, q, n); chk(n == 1, "R11 cmd completes at once", n, 1);
        rd_val = 8'h66;
        hx(3'd6, 1'b0, 8'h00, q, n); chk(n == 1 && q == 8'h00, "R11 read returns zero", q, 0);
        go_idle(4);

        chk(sb.size() == 0, "R8 all cycles seen", sb.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule